// File: doc/BRIEF.md
# Dual-Rank Serial Configuration Port

This block is a 3-wire serial slave that holds the configuration of two measurement channels, called A and B. A host shifts 16-bit words in on a serial data line while chip select is low. The ten upper bits of each word are a channel setting. Four lower bits say which channel's staging register takes that setting and which channels copy staging into the live register when chip select returns high. Each channel has two ranks: a staging (input) register and a live (active) register. The live register drives the channel's 10-bit configuration output.

A live update can be held back until a later moment, so that many channels or devices change together. Three things can trigger it: a level-sensitive active-low load pin, a later word that carries only copy bits, or a chip-select pulse with no serial clock in it. The serial output replays the previous word MSB first, so several ports can be chained. All pins are sampled by a system clock at least four times faster than the serial clock, through two-flop synchronizers.

Top module: `dual_cfg_port`

## Requirements
- R1: A word is 16 bits long. It is shifted in MSB first on each serial-clock rising edge while chip select is low. Bits 15..6 carry the 10-bit channel setting and bits 5..4 are ignored.
- R2: When chip select rises after exactly 16 clocks, address bit 2 set writes the setting into A's staging register and address bit 3 set writes it into B's. Both bits set write the same value to both. A staged value alone does not change the live outputs.
- R3: On the same event, control bit 0 copies A's staging register to its live register and control bit 1 does the same for B. When a channel is written and copied in one word, its live register takes the new setting.
- R4: A word whose bits 3..0 are all zero changes neither rank of either channel.
- R5: While the load pin is low, both live registers follow their staging registers, and this includes values written while the pin stays low. When the pin is high, this path has no effect.
- R6: A chip-select low pulse with no serial-clock rising edge inside it copies both staging registers to the live registers.
- R7: If chip select rises after a count of serial-clock rising edges other than 0 or 16, neither rank changes.
- R8: The serial output changes only after serial-clock falling edges. During a frame it replays the word shifted in before that frame, MSB first, one bit per falling edge. This includes the bits of a discarded partial frame.
- R9: After reset, both live outputs, both staging registers and the serial output are zero.
- R10: A channel's update strobe is high for exactly one system cycle, in the first cycle the live output shows a changed value. It never pulses when the value stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| load_ni | input | 1 | Level-sensitive load, active low |
| sdo_o | output | 1 | Serial data out for chaining |
| cfg_a_o | output | CFG_W | Live setting of channel A |
| cfg_b_o | output | CFG_W | Live setting of channel B |
| upd_a_o | output | 1 | One-cycle strobe on a change of cfg_a_o |
| upd_b_o | output | 1 | One-cycle strobe on a change of cfg_b_o |

## Verification
The assertions assume that the synchronized chip select never changes in the same system cycle as a synchronized serial-clock edge. They also assume that each serial-clock phase lasts longer than the synchronizer delay, so no edge is merged or lost. The stimulus keeps to this. Each serial-clock phase lasts eight system cycles, chip select moves only while the serial clock is low and idle for a full phase, and the load pin changes only between frames.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
  localparam int unsigned HDR_W = 6;    // reserved + address + control
  localparam int unsigned NCH   = 2;
  localparam int unsigned ADDR_LSB = 2; // channel c address bit = ADDR_LSB + c
  localparam int unsigned CTL_LSB  = 0; // channel c copy bit    = CTL_LSB + c
endpackage

// File: rtl/dcfg_sync.sv
module dcfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dcfg_shift.sv
module dcfg_shift #(
  parameter int unsigned CFG_W = 10,
  localparam int unsigned FRAME_W = CFG_W + dcfg_pkg::HDR_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_low_i,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             sdi_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [3:0]       cmd_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             sdo_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               spill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      spill_q <= 1'b0;
      sdo_o   <= 1'b0;
    end else begin
      if (cs_fall_i) begin
        cnt_q <= '0;
      end else if (sclk_rise_i && cs_low_i) begin
        sh_q    <= {sh_q[FRAME_W-2:0], sdi_i};
        spill_q <= sh_q[FRAME_W-1];
        if (cnt_q != CNT_W'(FRAME_W + 1)) cnt_q <= cnt_q + 1'b1;
      end
      // last stage leaves on a rise, shows on the following fall
      if (sclk_fall_i && cs_low_i) sdo_o <= spill_q;
    end
  end

  assign cfg_o   = sh_q[FRAME_W-1 -: CFG_W];
  assign cmd_o   = sh_q[3:0];
  assign full_o  = cs_rise_i && (cnt_q == CNT_W'(FRAME_W));
  assign empty_o = cs_rise_i && (cnt_q == '0);

  p_sdo_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall_i |=> $stable(sdo_o));
  p_cnt_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> !full_o);
endmodule

// File: rtl/dcfg_rank.sv
module dcfg_rank #(
  parameter int unsigned CFG_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             cp_i,
  input  logic             load_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] act_o,
  output logic             stb_o
);
  logic [CFG_W-1:0] in_q, in_d;
  logic             upd;

  assign in_d = wr_i ? data_i : in_q;
  assign upd  = cp_i || load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      act_o <= '0;
      stb_o <= 1'b0;
    end else begin
      in_q  <= in_d;
      stb_o <= upd && (in_d != act_o);
      if (upd) act_o <= in_d;
    end
  end

  p_strobe_change_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> (act_o != $past(act_o)));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !cp_i && !load_i) |=> $stable(act_o));
  p_load_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (act_o == in_q));
  p_write_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && cp_i) |=> (act_o == $past(data_i)));
endmodule

// File: rtl/dual_cfg_port.sv
module dual_cfg_port #(
  parameter int unsigned CFG_W       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csn_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             load_ni,
  output logic             sdo_o,
  output logic [CFG_W-1:0] cfg_a_o,
  output logic [CFG_W-1:0] cfg_b_o,
  output logic             upd_a_o,
  output logic             upd_b_o
);
  import dcfg_pkg::*;

  logic csn_s, sclk_s, sdi_s, load_ns;
  logic csn_d, sclk_d;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [CFG_W-1:0] cfg_w;
  logic [3:0]       cmd_w;
  logic             full_w, empty_w;
  logic [NCH-1:0]   wr, cp;
  logic [NCH-1:0][CFG_W-1:0] act;
  logic [NCH-1:0]   stb;

  dcfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sclk_i, sdi_i, load_ni}),
    .q_o   ({csn_s, sclk_s, sdi_s, load_ns})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_d  <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      csn_d  <= csn_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall   = csn_d && !csn_s;
  assign cs_rise   = !csn_d && csn_s;
  assign sclk_rise = !sclk_d && sclk_s;
  assign sclk_fall = sclk_d && !sclk_s;

  dcfg_shift #(.CFG_W(CFG_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_low_i   (!csn_s),
    .cs_fall_i  (cs_fall),
    .cs_rise_i  (cs_rise),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .sdi_i      (sdi_s),
    .cfg_o      (cfg_w),
    .cmd_o      (cmd_w),
    .full_o     (full_w),
    .empty_o    (empty_w),
    .sdo_o      (sdo_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr[c] = full_w && cmd_w[ADDR_LSB + c];
    assign cp[c] = (full_w && cmd_w[CTL_LSB + c]) || empty_w;

    dcfg_rank #(.CFG_W(CFG_W)) u_rank (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr[c]),
      .cp_i  (cp[c]),
      .load_i(!load_ns),
      .data_i(cfg_w),
      .act_o (act[c]),
      .stb_o (stb[c])
    );
  end

  assign cfg_a_o = act[0];
  assign cfg_b_o = act[1];
  assign upd_a_o = stb[0];
  assign upd_b_o = stb[1];

  p_wr_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr[0] |=> !wr[0]);
  p_quick_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_w |-> (cp == '1 && wr == '0));
  p_strobe_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_a_o |=> !upd_a_o);
endmodule

// File: tb/sim_dual_cfg_port.sv
module sim_dual_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8 * CLK_PERIOD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
  logic sdo, upd_a, upd_b;
  logic [9:0] cfg_a, cfg_b;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [9:0] qa[$], qb[$];
  logic [9:0] m_in[2], m_act[2];
  logic [15:0] m_sh = '0;
  bit load_low = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .load_ni(load_n), .sdo_o(sdo), .cfg_a_o(cfg_a), .cfg_b_o(cfg_b),
    .upd_a_o(upd_a), .upd_b_o(upd_b)
  );

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor (R10)
  always @(negedge clk) if (rst_n && !done) begin
    if (upd_a) begin
      if (qa.size() == 0) chk(0, "R10 unexpected strobe A", {6'd0, cfg_a}, '0);
      else begin logic [9:0] e; e = qa.pop_front(); chk(cfg_a == e, "R10 strobe A value", {6'd0, cfg_a}, {6'd0, e}); end
    end
    if (upd_b) begin
      if (qb.size() == 0) chk(0, "R10 unexpected strobe B", {6'd0, cfg_b}, '0);
      else begin logic [9:0] e; e = qb.pop_front(); chk(cfg_b == e, "R10 strobe B value", {6'd0, cfg_b}, {6'd0, e}); end
    end
  end

  task automatic set_act(int ch, logic [9:0] v);
    if (v != m_act[ch]) begin
      if (ch == 0) qa.push_back(v); else qb.push_back(v);
    end
    m_act[ch] = v;
  endtask

  function automatic logic [15:0] word(logic [9:0] cfg, logic [1:0] addr, logic [1:0] ctl);
    return {cfg, 2'b11, addr, ctl};
  endfunction

  task automatic send(logic [15:0] w, int n, string tag);
    logic [15:0] s, got, exp;
    int bad;
    s = m_sh; bad = 0; got = '0; exp = '0;
    csn = 1'b0;
    #(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = w[15-i];
      #(HALF);
      if (i > 0) begin
        got[16-i] = sdo; exp[16-i] = s[16-i];
        if (sdo !== s[16-i]) bad++;
      end
      sclk = 1'b1;
      m_sh = {m_sh[14:0], w[15-i]};
      #(HALF);
      sclk = 1'b0;
    end
    #(HALF);
    if (n > 0) begin
      got[16-n] = sdo; exp[16-n] = s[16-n];
      if (sdo !== s[16-n]) bad++;
      chk(bad == 0, {"R8 sdo replay ", tag}, got, exp);
    end
    // model the chip-select rise
    if (n == 16) begin
      for (int c = 0; c < 2; c++) begin
        if (w[2+c]) m_in[c] = w[15:6];
        if (w[c] || load_low) set_act(c, m_in[c]);
      end
    end else if (n == 0) begin
      for (int c = 0; c < 2; c++) set_act(c, m_in[c]);
    end
    csn = 1'b1;
    #(10 * CLK_PERIOD);
  endtask

  task automatic chk_act(string tag);
    chk(cfg_a == m_act[0] && cfg_b == m_act[1], tag, {cfg_a, 6'd0}, {m_act[0], 6'd0});
    chk(cfg_b == m_act[1], {tag, " chB"}, {6'd0, cfg_b}, {6'd0, m_act[1]});
  endtask

  initial begin
    m_in[0] = '0; m_in[1] = '0; m_act[0] = '0; m_act[1] = '0;
    #(5 * CLK_PERIOD);
    rst_n = 1'b1;
    #(5 * CLK_PERIOD);
    chk(cfg_a == 0 && cfg_b == 0 && sdo == 0, "R9 reset state", {5'd0, sdo, cfg_a}, '0);

    send(word(10'h2A5, 2'b01, 2'b00), 16, "R2 stage A");
    chk_act("R2 staged only, live unchanged");
    send('0, 0, "R6 pulse");
    chk_act("R6 quick load copies staged A");

    send(word(10'h3C3, 2'b11, 2'b11), 16, "R3 both");
    chk_act("R2 R3 write+copy both");

    send(word(10'h155, 2'b10, 2'b10), 16, "R3 B");
    chk_act("R3 write+copy B only");

    send(word(10'h0F0, 2'b01, 2'b00), 16, "R1 stage A");
    send(word(10'h3FF, 2'b00, 2'b01), 16, "R3 copy only");
    chk_act("R3 copy-only word ignores its data");

    send(word(10'h1AB, 2'b00, 2'b00), 16, "R4 nop");
    chk_act("R4 no-op word");

    send(word(10'h2DD, 2'b11, 2'b11), 9, "R7 partial 9");
    chk_act("R7 partial frame discarded");
    send(word(10'h0AA, 2'b11, 2'b11), 15, "R7 partial 15");
    chk_act("R7 15-bit frame discarded");
    send(word(10'h111, 2'b10, 2'b00), 16, "R8 after partial");
    chk_act("R2 stage B after partial");

    load_n = 1'b0; load_low = 1;
    set_act(0, m_in[0]); set_act(1, m_in[1]);
    #(10 * CLK_PERIOD);
    chk_act("R5 load low copies staged");
    send(word(10'h222, 2'b01, 2'b00), 16, "R5 while low");
    chk_act("R5 write during load low reaches live");
    load_n = 1'b1; load_low = 0;
    #(10 * CLK_PERIOD);
    send(word(10'h333, 2'b01, 2'b00), 16, "R5 after release");
    chk_act("R5 load high has no effect");
    send('0, 0, "R6 pulse 2");
    chk_act("R6 quick load after release");

    #(20 * CLK_PERIOD);
    chk(qa.size() == 0 && qb.size() == 0, "R10 all strobes seen",
        16'(qa.size() + qb.size()), '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule